// File: doc/BRIEF.md
# Dual-Channel Keyed and Swept Sine Synthesizer

This block is the digital core of a two-output sine synthesizer. Both channels run from one system clock and one reset. Each channel keeps its own phase accumulator, a 32-bit frequency word, a 14-bit phase word and a 10-bit amplitude word. Every clock it turns the accumulator phase into a signed 10-bit sine sample through a table and scales that sample by the amplitude word. Because the channels share the clock and are cleared together, two channels given the same settings in the same clock stay locked to each other. The highest useful output frequency is half the clock rate.

Software writes the per-channel words into a staging bank through a simple write port. A per-channel commit strobe copies the whole staging bank into the active bank in one clock, so all of a channel's words change at the same clock. Each channel runs in one of three modes. In plain tone mode it uses its base words. In keyed mode four select pins choose one of sixteen profile words, which replaces the frequency, the phase or the amplitude; this gives 16-level FSK, PSK or ASK. In sweep mode the frequency starts at the base word, rises by a step word every N clocks, and stops at an end word.

Top module: `dds_dual_core`

## Requirements
- R1: A synchronous active-low reset clears the staging words, the active words, the accumulators and the sweep state of both channels. Both samples are 0 during reset and stay 0 until a commit makes a nonzero amplitude active.
- R2: In each clock the phase index P is the top 12 bits of (top 14 accumulator bits + effective phase word) mod 2^14. A is the effective amplitude in that same clock. The sample registered two clock edges later is within 2 LSB of 511·sin(2π(P+0.5)/4096)·A/1024.
- R3: Each clock the accumulator adds the effective frequency word modulo 2^32. A frequency word of 2^31 gives consecutive samples of opposite sign: their sum is within ±1 and their magnitude is at least 500 when the phase word is 4096.
- R4: The 14-bit phase word is added to the top 14 accumulator bits. A value of 4096 shifts the channel by a quarter cycle.
- R5: The amplitude word (0 to 1023) scales the sine output with rounding. An amplitude of 0 gives samples that are exactly 0.
- R6: Writes go to the staging bank only and do not change the output until a commit bit for that channel is high at a clock edge. A commit copies every staged word at once and leaves the other channel unchanged. A write in the same clock as a commit does not reach the active bank until the next commit.
- R7: When both channels are given identical words and are committed in the same clock after reset, their samples are equal in every clock.
- R8: In keyed mode (control bits [1:0] = 1), control bits [3:2] select the target: 0 = frequency, 1 = phase (profile bits [13:0]), 2 = amplitude (profile bits [9:0]), 3 = no keying. The channel's select pins choose profile 0 to 15. The words that are not targeted come from the base words. A change on the pins moves the accumulator at the next edge.
- R9: In sweep mode (control bits [1:0] = 2), a commit loads the sweep frequency with the staged frequency word. Every (ramp-rate + 1) clocks it adds the step word while it is below the end word. It clamps to the end word when the remaining distance is at most the step, and it then holds. It never steps when it starts above the end word.
- R10: The register address map is: 0 control, 1 frequency, 2 phase, 3 amplitude, 4 sweep step, 5 ramp rate (16 bits), 6 sweep end, 16 to 31 profiles 0 to 15. Control mode value 3 behaves as plain tone mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock |
| rst_n | input | 1 | Synchronous active-low reset for both channels |
| wr_en | input | 1 | Staging write enable |
| wr_chan | input | 1 | Channel chosen by the write |
| wr_addr | input | 5 | Staging word address |
| wr_data | input | 32 | Staging write data |
| commit | input | 2 | Per-channel staging-to-active copy strobe |
| prof0 | input | 4 | Profile select pins, channel 0 |
| prof1 | input | 4 | Profile select pins, channel 1 |
| samp0 | output | 10 | Signed sample, channel 0 |
| samp1 | output | 10 | Signed sample, channel 1 |

## Verification
The hardest state to reach from the ports is the end of a sweep. There the last step would overshoot the end word and must clamp instead. A sweep that starts above its end word must never move. The stimulus gets there with a step that does not divide the distance, with a zero ramp rate so a step comes every clock, and with a start word above the end word. A behavioural model follows the sweep frequency and the phase. Any wrong step or missing clamp then shows as phase drift that grows in every later sample. Profile pins are walked through all sixteen values for each keyed target, and the pins of an idle channel are toggled at the same time.

// File: rtl/dds_pkg.sv
// Shared encodings for the dual-channel synthesizer.
// Assumes: control word bits [1:0] hold the mode, bits [3:2] the keying target.
package dds_pkg;
    typedef enum logic [1:0] {
        MODE_TONE  = 2'd0,
        MODE_KEYED = 2'd1,
        MODE_SWEEP = 2'd2,
        MODE_ALT   = 2'd3
    } dds_mode_e;

    typedef enum logic [1:0] {
        KEY_FREQ  = 2'd0,
        KEY_PHASE = 2'd1,
        KEY_AMP   = 2'd2,
        KEY_NONE  = 2'd3
    } key_tgt_e;

    localparam int ADR_CTRL = 0;
    localparam int ADR_FTW  = 1;
    localparam int ADR_POW  = 2;
    localparam int ADR_ASF  = 3;
    localparam int ADR_STEP = 4;
    localparam int ADR_RATE = 5;
    localparam int ADR_END  = 6;
endpackage

// File: rtl/dds_sine_rom.sv
// Phase-to-amplitude converter with a registered output.
// Keeps only a quarter wave of magnitudes, built at elaboration by a rational
// sine approximation; the other quadrants come from mirroring and negation.
// Assumes: LUT_AW >= 3, peak value 2^(SMP_W-1)-1.
module dds_sine_rom #(
    parameter int LUT_AW = 12,
    parameter int SMP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LUT_AW-1:0]       idx,
    output logic signed [SMP_W-1:0] sin_q
);
    localparam int QD    = 2 ** (LUT_AW - 2);
    localparam int MAG_W = SMP_W - 1;
    localparam longint PEAK = (64'sd1 <<< MAG_W) - 1;

    function automatic logic [QD*MAG_W-1:0] build_quarter();
        logic [QD*MAG_W-1:0] tbl;
        longint hp, t, pr, num, den, v;
        tbl = '0;
        hp = 4 * QD;
        for (int k = 0; k < QD; k++) begin
            t   = 2 * k + 1;
            pr  = t * (hp - t);
            num = 4 * PEAK * pr;
            den = (5 * hp * hp) / 4 - pr;
            v   = (2 * num + den) / (2 * den);
            tbl[k*MAG_W +: MAG_W] = MAG_W'(v);
        end
        return tbl;
    endfunction

    localparam logic [QD*MAG_W-1:0] QUARTER = build_quarter();

    logic [LUT_AW-3:0] qidx;
    logic [MAG_W-1:0]  mag;

    // Mirror the index in the second and fourth quadrants and fetch the magnitude.
    always_comb begin
        qidx = idx[LUT_AW-2] ? ~idx[LUT_AW-3:0] : idx[LUT_AW-3:0];
        mag  = QUARTER[qidx*MAG_W +: MAG_W];
    end

    // Register the signed sample, negated in the second half cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sin_q <= '0;
        else if (idx[LUT_AW-1])
            sin_q <= -$signed({1'b0, mag});
        else
            sin_q <= $signed({1'b0, mag});
    end

    // R2
    sine_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sin_q != {1'b1, {(SMP_W-1){1'b0}}});
endmodule

// File: rtl/dds_amp_scale.sv
// Amplitude scaler: multiplies a signed sample by an unsigned scale word and
// rounds the product back to the sample width (half-LSB bias, floor).
// Assumes: scale full range is 2^ASF_W, so the result never overflows.
module dds_amp_scale #(
    parameter int SMP_W = 10,
    parameter int ASF_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] sin_in,
    input  logic [ASF_W-1:0]        asf_in,
    output logic signed [SMP_W-1:0] samp
);
    localparam int PW = SMP_W + ASF_W + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (ASF_W - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    // Form the rounded product.
    always_comb begin
        prod   = sin_in * $signed({1'b0, asf_in});
        biased = prod + HALF;
    end

    // Register the scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            samp <= '0;
        else
            samp <= SMP_W'(biased >>> ASF_W);
    end

    // R5
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asf_in == '0) |=> (samp == '0));
endmodule

// File: rtl/dds_channel.sv
// One synthesizer channel: staging and active word banks, mode selection,
// frequency sweep stepper, phase accumulator and the sample pipeline.
// Assumes: ADR_W = SEL_W + 1, profiles live in the upper half of the address map.
module dds_channel
    import dds_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int POW_W  = 14,
    parameter int ASF_W  = 10,
    parameter int LUT_AW = 12,
    parameter int SMP_W  = 10,
    parameter int RR_W   = 16,
    parameter int NPROF  = 16,
    localparam int SEL_W = $clog2(NPROF),
    localparam int ADR_W = SEL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADR_W-1:0]        wr_addr,
    input  logic [ACC_W-1:0]        wr_data,
    input  logic                    commit,
    input  logic [SEL_W-1:0]        prof_sel,
    output logic signed [SMP_W-1:0] samp
);
    localparam logic [ADR_W-1:0] PROF_BASE = ADR_W'(NPROF);

    logic [3:0]       stg_ctrl, act_ctrl;
    logic [ACC_W-1:0] stg_ftw, act_ftw, stg_step, act_step, stg_end, act_end;
    logic [POW_W-1:0] stg_pow, act_pow;
    logic [ASF_W-1:0] stg_asf, act_asf;
    logic [RR_W-1:0]  stg_rate, act_rate;
    logic [ACC_W-1:0] stg_prof [NPROF];
    logic [ACC_W-1:0] act_prof [NPROF];

    dds_mode_e        mode;
    key_tgt_e         tgt;
    logic [ACC_W-1:0] ftw_e, sw_freq, acc;
    logic [POW_W-1:0] pow_e, phase;
    logic [ASF_W-1:0] asf_e, asf_q;
    logic [RR_W-1:0]  sw_cnt;
    logic [LUT_AW-1:0] idx;
    logic signed [SMP_W-1:0] sin_q;

    assign mode = dds_mode_e'(act_ctrl[1:0]);
    assign tgt  = key_tgt_e'(act_ctrl[3:2]);

    // Capture register writes into the staging bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ctrl <= '0; stg_ftw <= '0; stg_pow <= '0; stg_asf <= '0;
            stg_step <= '0; stg_rate <= '0; stg_end <= '0;
            for (int i = 0; i < NPROF; i++) stg_prof[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr >= PROF_BASE)
                stg_prof[wr_addr[SEL_W-1:0]] <= wr_data;
            else begin
                case (int'(wr_addr))
                    ADR_CTRL: stg_ctrl <= wr_data[3:0];
                    ADR_FTW:  stg_ftw  <= wr_data;
                    ADR_POW:  stg_pow  <= wr_data[POW_W-1:0];
                    ADR_ASF:  stg_asf  <= wr_data[ASF_W-1:0];
                    ADR_STEP: stg_step <= wr_data;
                    ADR_RATE: stg_rate <= wr_data[RR_W-1:0];
                    ADR_END:  stg_end  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Copy the whole staging bank to the active bank on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctrl <= '0; act_ftw <= '0; act_pow <= '0; act_asf <= '0;
            act_step <= '0; act_rate <= '0; act_end <= '0;
            for (int i = 0; i < NPROF; i++) act_prof[i] <= '0;
        end else if (commit) begin
            act_ctrl <= stg_ctrl; act_ftw <= stg_ftw; act_pow <= stg_pow;
            act_asf <= stg_asf; act_step <= stg_step; act_rate <= stg_rate;
            act_end <= stg_end;
            for (int i = 0; i < NPROF; i++) act_prof[i] <= stg_prof[i];
        end
    end

    // Pick the effective frequency, phase and amplitude for the current mode.
    always_comb begin
        ftw_e = act_ftw;
        pow_e = act_pow;
        asf_e = act_asf;
        if (mode == MODE_SWEEP)
            ftw_e = sw_freq;
        else if (mode == MODE_KEYED) begin
            case (tgt)
                KEY_FREQ:  ftw_e = act_prof[prof_sel];
                KEY_PHASE: pow_e = act_prof[prof_sel][POW_W-1:0];
                KEY_AMP:   asf_e = act_prof[prof_sel][ASF_W-1:0];
                default: ;
            endcase
        end
    end

    // Step the sweep frequency every (rate + 1) clocks and clamp at the end word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_freq <= '0;
            sw_cnt  <= '0;
        end else if (commit) begin
            sw_freq <= stg_ftw;
            sw_cnt  <= '0;
        end else if (mode == MODE_SWEEP) begin
            if (sw_cnt == act_rate) begin
                sw_cnt <= '0;
                if (sw_freq < act_end) begin
                    if ((act_end - sw_freq) <= act_step)
                        sw_freq <= act_end;
                    else
                        sw_freq <= sw_freq + act_step;
                end
            end else
                sw_cnt <= sw_cnt + 1'b1;
        end
    end

    // Advance the phase accumulator and align the amplitude with the table stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            asf_q <= '0;
        end else begin
            acc   <= acc + ftw_e;
            asf_q <= asf_e;
        end
    end

    // Add the phase word to the top accumulator bits and truncate to the table index.
    always_comb begin
        phase = acc[ACC_W-1 -: POW_W] + pow_e;
        idx   = LUT_AW'(phase >> (POW_W - LUT_AW));
    end

    dds_sine_rom #(.LUT_AW(LUT_AW), .SMP_W(SMP_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .idx(idx), .sin_q(sin_q)
    );

    dds_amp_scale #(.SMP_W(SMP_W), .ASF_W(ASF_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .sin_in(sin_q), .asf_in(asf_q), .samp(samp)
    );

    // R9
    sweep_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SWEEP && !commit && sw_freq <= act_end) |=> (sw_freq <= act_end));

    // R9
    sweep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SWEEP && !commit) |=> (sw_freq >= $past(sw_freq)));

    // R9
    ramp_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cnt <= act_rate);
endmodule

// File: rtl/dds_dual_core.sv
// Top of the dual-channel synthesizer: two identical channels on one clock
// and one reset, a shared write port steered by channel, per-channel commit.
// Assumes: exactly two channels, fixed by the port list.
module dds_dual_core #(
    parameter int ACC_W  = 32,
    parameter int POW_W  = 14,
    parameter int ASF_W  = 10,
    parameter int LUT_AW = 12,
    parameter int SMP_W  = 10,
    parameter int RR_W   = 16,
    parameter int NPROF  = 16,
    localparam int SEL_W = $clog2(NPROF),
    localparam int ADR_W = SEL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_chan,
    input  logic [ADR_W-1:0]        wr_addr,
    input  logic [ACC_W-1:0]        wr_data,
    input  logic [1:0]              commit,
    input  logic [SEL_W-1:0]        prof0,
    input  logic [SEL_W-1:0]        prof1,
    output logic signed [SMP_W-1:0] samp0,
    output logic signed [SMP_W-1:0] samp1
);
    localparam int NCH = 2;

    logic signed [SMP_W-1:0] samp_w [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [SEL_W-1:0] sel;
        logic             ch_wr;
        assign sel   = (ch == 0) ? prof0 : prof1;
        assign ch_wr = wr_en && (wr_chan == 1'(ch));

        dds_channel #(
            .ACC_W(ACC_W), .POW_W(POW_W), .ASF_W(ASF_W), .LUT_AW(LUT_AW),
            .SMP_W(SMP_W), .RR_W(RR_W), .NPROF(NPROF)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .wr_en(ch_wr), .wr_addr(wr_addr),
            .wr_data(wr_data), .commit(commit[ch]), .prof_sel(sel),
            .samp(samp_w[ch])
        );
    end

    assign samp0 = samp_w[0];
    assign samp1 = samp_w[1];
endmodule

// File: tb/dds_dual_core_bench.sv
`timescale 1ns/1ps
module dds_dual_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_chan = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  commit = '0;
    logic [3:0]  prof0 = '0;
    logic [3:0]  prof1 = '0;
    logic signed [9:0] samp0, samp1;

    always #10 clk = ~clk;

    dds_dual_core u_dds_dual_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
        .prof0(prof0), .prof1(prof1), .samp0(samp0), .samp1(samp1)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;

    // Behavioural reference: word banks indexed by address, plain integers.
    longint stg [2][32];
    longint act [2][32];
    longint acc [2];
    longint swf [2];
    longint swc [2];
    int     pipe_idx [2];
    int     pipe_asf [2];
    real    expv [2];

    localparam longint M32 = 64'hFFFF_FFFF;
    localparam real    TWO_PI = 6.283185307179586;

    function automatic void model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 32; a++) begin stg[c][a] = 0; act[c][a] = 0; end
            acc[c] = 0; swf[c] = 0; swc[c] = 0;
            pipe_idx[c] = 0; pipe_asf[c] = 0; expv[c] = 0.0;
        end
    endfunction

    function automatic void model_step(int c, int sel, bit cm);
        longint mode, tgt, f, p, a, fin, stepw, rate;
        mode = act[c][0] & 3;
        tgt  = (act[c][0] >> 2) & 3;
        f = act[c][1]; p = act[c][2] & 16383; a = act[c][3] & 1023;
        if (mode == 2) f = swf[c];
        else if (mode == 1) begin
            if (tgt == 0) f = act[c][16+sel];
            else if (tgt == 1) p = act[c][16+sel] & 16383;
            else if (tgt == 2) a = act[c][16+sel] & 1023;
        end
        expv[c] = 511.0 * $sin(TWO_PI * (real'(pipe_idx[c]) + 0.5) / 4096.0)
                  * real'(pipe_asf[c]) / 1024.0;
        pipe_idx[c] = int'((((acc[c] >> 18) + p) & 16383) >> 2);
        pipe_asf[c] = int'(a);
        acc[c] = (acc[c] + f) & M32;
        fin = act[c][6]; stepw = act[c][4]; rate = act[c][5] & 65535;
        if (cm) begin
            for (int k = 0; k < 32; k++) act[c][k] = stg[c][k];
            swf[c] = stg[c][1];
            swc[c] = 0;
        end else if (mode == 2) begin
            if (swc[c] == rate) begin
                swc[c] = 0;
                if (swf[c] < fin) swf[c] = (fin - swf[c] <= stepw) ? fin : swf[c] + stepw;
            end else swc[c] = swc[c] + 1;
        end
    endfunction

    // Advance the reference model on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            model_step(0, int'(prof0), commit[0]);
            model_step(1, int'(prof1), commit[1]);
            if (wr_en) stg[wr_chan][wr_addr] = longint'(wr_data);
        end
    end

    task automatic check(bit ok, string req, string what, int actual, int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Compare both sample streams with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int v [2];
            v[0] = int'(samp0);
            v[1] = int'(samp1);
            for (int c = 0; c < 2; c++) begin
                real d;
                d = real'(v[c]) - expv[c];
                n_checks++;
                if (d > 2.0 || d < -2.0) begin
                    n_fail++;
                    $display("FAIL %s ch%0d sample: actual %0d expected %0.2f", tag, c, v[c], expv[c]);
                end
            end
        end
    end

    task automatic wr(int c, int a, logic [31:0] d);
        wr_en = 1'b1; wr_chan = c[0]; wr_addr = a[4:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cm(logic [1:0] m);
        commit = m;
        @(negedge clk);
        commit = '0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int prev;
        @(negedge clk);
        // R1: outputs held at zero during reset
        run(3);
        check(samp0 == 0 && samp1 == 0, "R1", "reset outputs", int'(samp0), 0);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        run(4);
        check(samp0 == 0 && samp1 == 0, "R1", "after reset", int'(samp1), 0);

        // R2 / R10: plain tone on channel 0 only
        tag = "R2";
        wr(0, 0, 0); wr(0, 1, 32'h0147_AE14); wr(0, 2, 0); wr(0, 3, 1023);
        cm(2'b01);
        for (int i = 0; i < 40; i++) begin
            // R6: channel 1 untouched by channel 0 commit
            check(samp1 == 0, "R6", "idle channel", int'(samp1), 0);
            run(1);
        end

        // R6: staged write without commit has no effect
        tag = "R6";
        wr(0, 1, 32'h1000_0000);
        run(30);
        // R6: write in the same clock as commit waits for the next commit
        wr_en = 1'b1; wr_chan = 1'b0; wr_addr = 5'd3; wr_data = 32'd200; commit = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; commit = '0;
        run(30);
        cm(2'b01);
        run(30);

        // R7: identical settings committed together after reset
        do_reset();
        tag = "R7";
        wr(0, 1, 32'h00C0_0000); wr(0, 3, 800);
        wr(1, 1, 32'h00C0_0000); wr(1, 3, 800);
        cm(2'b11);
        for (int i = 0; i < 60; i++) begin
            check(samp0 == samp1, "R7", "channel match", int'(samp1), int'(samp0));
            run(1);
        end
        // R4: quarter-cycle offset on channel 1
        tag = "R4";
        wr(1, 2, 4096);
        cm(2'b10);
        run(60);

        // R3: Nyquist-rate tone alternates sign
        do_reset();
        tag = "R3";
        wr(0, 1, 32'h8000_0000); wr(0, 2, 4096); wr(0, 3, 1023);
        cm(2'b01);
        run(3);
        prev = int'(samp0);
        for (int i = 0; i < 20; i++) begin
            int cur;
            run(1);
            cur = int'(samp0);
            check((cur + prev) <= 1 && (cur + prev) >= -1 && (cur >= 500 || cur <= -500),
                  "R3", "alternating sample", cur, -prev);
            prev = cur;
        end

        // R5: amplitude zero mutes, then partial amplitude
        tag = "R5";
        wr(0, 1, 32'h0147_AE14); wr(0, 2, 0); wr(0, 3, 0);
        cm(2'b01);
        run(3);
        for (int i = 0; i < 30; i++) begin
            check(samp0 == 0, "R5", "muted sample", int'(samp0), 0);
            run(1);
        end
        wr(0, 3, 300); cm(2'b01); run(40);
        wr(0, 3, 1023); cm(2'b01); run(20);

        // R10: control mode 3 acts as plain tone
        tag = "R10";
        wr(0, 0, 3); wr(0, 1, 32'h0300_0000);
        cm(2'b01);
        run(30);

        // R8: frequency keying across all profiles, idle channel pins toggling
        tag = "R8";
        for (int i = 0; i < 16; i++) wr(0, 16 + i, (i + 1) * 32'h0080_0000);
        wr(0, 0, 1 | (0 << 2));
        cm(2'b01);
        for (int i = 0; i < 16; i++) begin prof0 = i[3:0]; prof1 = 4'(15 - i); run(9); end
        // R8: phase keying
        for (int i = 0; i < 16; i++) wr(0, 16 + i, i * 1024);
        wr(0, 1, 32'h0040_0000); wr(0, 0, 1 | (1 << 2));
        cm(2'b01);
        for (int i = 0; i < 16; i++) begin prof0 = 4'(15 - i); run(9); end
        // R8: amplitude keying
        for (int i = 0; i < 16; i++) wr(0, 16 + i, i * 64 + 63);
        wr(0, 0, 1 | (2 << 2));
        cm(2'b01);
        for (int i = 0; i < 16; i++) begin prof0 = i[3:0]; run(9); end
        // R8: target 3 means no keying
        wr(0, 0, 1 | (3 << 2));
        cm(2'b01);
        for (int i = 0; i < 8; i++) begin prof0 = 4'(i * 2); run(5); end

        // R9: sweep with ramp rate 3, step divides the span
        tag = "R9";
        wr(0, 0, 2); wr(0, 1, 32'h0100_0000); wr(0, 4, 32'h0040_0000);
        wr(0, 5, 3); wr(0, 6, 32'h0400_0000);
        cm(2'b01);
        run(120);
        // R9: step every clock with a clamped final step
        wr(0, 4, 32'h0030_0000); wr(0, 5, 0); wr(0, 6, 32'h0210_0000);
        cm(2'b01);
        run(60);
        // R9: start above end never steps
        wr(0, 1, 32'h0500_0000); wr(0, 6, 32'h0200_0000);
        cm(2'b01);
        run(40);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule